// File: doc/BRIEF.md
# Configuration Control Coprocessor Register Bank

This block is a small bank of control registers beside a processor core. The core reaches it only through register-move operations. Each operation arrives as a one-cycle strobe carrying a read/write flag, the 32-bit instruction word and the write data. The register number is taken from a fixed field of the instruction word. The bank holds eight 32-bit registers. Register 0 always reads back a hard-wired identification constant. The configuration register (register 1) drives four configuration outputs to the core:

- program address width
- data address width
- abort timing
- byte order

At reset the configuration register loads its four control bits from strap inputs.

A second, debug port reaches the same registers by a direct index. The core-side request interface applies no back-pressure: there is no ready signal, every strobed request is accepted in the cycle it is presented, and the done response follows exactly one cycle later. A new request may be issued in every cycle. When a write changes any configuration bit, the block raises a one-cycle mode-change pulse so that the core can pick up the new settings.

Top module: `cfgcp_bank`

## Requirements
- R1: During and after reset, register 1 holds the strap inputs in bits 7:4 (strap bit 0 at bit 4) and zero in every other bit. Registers 2 to 7 read zero. The configuration outputs equal the straps. `rsp_done`, `mode_change`, `rsp_rdata` and `dbg_rdata` are zero.
- R2: The core port register number is instruction bits 18:16. Bit 19 and all other instruction bits have no effect on which register is accessed.
- R3: Reading register 0 on either port returns 0x41440110. This holds whatever was last written to register 0.
- R4: A write to register 1 to 7 stores all 32 bits. A later read of that register returns them on `rsp_rdata` or `dbg_rdata`, one cycle after the read strobe.
- R5: Every strobed core request (`req_valid` high at a clock edge) raises `rsp_done` for exactly the following cycle. `rsp_done` is low after any edge where `req_valid` was low.
- R6: After a write to register 1, from the next cycle onward the outputs take their values from the written word:
  - `cfg_prog32` from bit 4
  - `cfg_data32` from bit 5
  - `cfg_late_abort` from bit 6
  - `cfg_big_endian` from bit 7

  The configuration outputs change only after such a write.
- R7: `mode_change` is high for the one cycle after a register-1 write that alters at least one of bits 7:4. It stays low after a register-1 write that leaves those bits unchanged, and after writes to any other register.
- R8: The debug port (`dbg_valid`, `dbg_write`, `dbg_idx`) reads and writes registers 0 to 7 with the same effects as the core port, including R6 and R7. Debug read data appears on `dbg_rdata` one cycle after the strobe.
- R9: A debug access with `dbg_idx` of 8 or more changes no register and no configuration output. `dbg_rdata` keeps its previous value.
- R10: When both ports write the same register in one cycle, the core port value is stored. Writes to different registers in one cycle both take effect.
- R11: `rsp_rdata` changes only after a core read, and `dbg_rdata` changes only after an in-range debug read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_cfg | input | 4 | Reset values for configuration bits 7:4 |
| req_valid | input | 1 | Core request strobe, one request per high cycle |
| req_write | input | 1 | 1 = move to register bank, 0 = move from it |
| req_instr | input | 32 | Instruction word; register number in bits 18:16 |
| req_wdata | input | 32 | Core write data |
| rsp_done | output | 1 | Completion, high one cycle after each request |
| rsp_rdata | output | 32 | Core read data, valid with `rsp_done` after a read |
| dbg_valid | input | 1 | Debug access strobe |
| dbg_write | input | 1 | 1 = debug write, 0 = debug read |
| dbg_idx | input | 4 | Debug register index, 8 and above ignored |
| dbg_wdata | input | 32 | Debug write data |
| dbg_rdata | output | 32 | Debug read data |
| cfg_prog32 | output | 1 | Program address width select |
| cfg_data32 | output | 1 | Data address width select |
| cfg_late_abort | output | 1 | Late abort timing select |
| cfg_big_endian | output | 1 | Big-endian byte order select |
| mode_change | output | 1 | One-cycle pulse when a configuration bit changes |

## Verification
The assertions take the strap inputs to be steady across reset release and afterwards. They also take both strobes and their qualifiers to be known (not X) at every edge outside reset. The bench sets the straps once before reset and never touches them again. It drives every input to a defined value on the falling edge, so that each rising edge sees settled request fields. The random mix covers both ports, every index including out-of-range debug indices, and register-1 writes that either keep or flip the configuration bits. Directed cases add the simultaneous-write conflict and writes to register 0.

// File: rtl/cfgcp_pkg.sv
package cfgcp_pkg;
  parameter int unsigned WORD_W   = 32;
  parameter int unsigned NUM_REGS = 8;
  parameter int unsigned NUM_CFG  = 4;
  localparam int unsigned IDX_W   = $clog2(NUM_REGS);
  localparam logic [WORD_W-1:0] ID_WORD = 32'h4144_0110;
  // index of the register carrying the configuration bits and their position
  localparam int unsigned CFG_REG = 1;
  localparam int unsigned CFG_LSB = 4;
  // position of the register-number field in the instruction word
  localparam int unsigned RN_LSB  = 16;

  typedef logic [IDX_W-1:0]  idx_t;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/cfgcp_decode.sv
module cfgcp_decode
  import cfgcp_pkg::*;
#(
  parameter int unsigned DBG_IDX_W = 4
) (
  input  logic [IDX_W-1:0]     rn_field,
  input  logic [DBG_IDX_W-1:0] dbg_idx,
  output idx_t                 core_idx,
  output idx_t                 dbg_sel,
  output logic                 dbg_in_range
);
  assign core_idx     = rn_field;
  assign dbg_sel      = dbg_idx[IDX_W-1:0];
  assign dbg_in_range = (32'(dbg_idx) < NUM_REGS);
endmodule

// File: rtl/cfgcp_regfile.sv
module cfgcp_regfile
  import cfgcp_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CFG-1:0] strap,
  input  logic               we_a,
  input  idx_t               idx_a,
  input  word_t              d_a,
  input  logic               we_b,
  input  idx_t               idx_b,
  input  word_t              d_b,
  input  idx_t               ridx_a,
  input  idx_t               ridx_b,
  output word_t              rd_a,
  output word_t              rd_b,
  output logic [NUM_CFG-1:0] cfg
);
  word_t regs [NUM_REGS];

  for (genvar i = 0; i < int'(NUM_REGS); i++) begin : g_reg
    if (i == 0) begin : g_id
      assign regs[i] = ID_WORD;
    end else begin : g_rw
      word_t init;
      if (i == int'(CFG_REG)) begin : g_cfg_init
        assign init = word_t'(strap) << CFG_LSB;
      end else begin : g_zero_init
        assign init = '0;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           regs[i] <= init;
        else if (we_a && idx_a == idx_t'(i))  regs[i] <= d_a;
        else if (we_b && idx_b == idx_t'(i))  regs[i] <= d_b;
      end
    end
  end

  assign rd_a = regs[ridx_a];
  assign rd_b = regs[ridx_b];
  assign cfg  = regs[CFG_REG][CFG_LSB +: NUM_CFG];
endmodule

// File: rtl/cfgcp_modewatch.sv
module cfgcp_modewatch
  import cfgcp_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CFG-1:0] cfg_cur,
  input  logic               cfg_we,
  input  logic [NUM_CFG-1:0] cfg_new,
  output logic               pulse
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse <= 1'b0;
    else        pulse <= cfg_we && (cfg_new != cfg_cur);
  end
endmodule

// File: rtl/cfgcp_bank.sv
module cfgcp_bank
  import cfgcp_pkg::*;
#(
  parameter int unsigned DBG_IDX_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CFG-1:0]   strap_cfg,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [WORD_W-1:0]    req_instr,
  input  logic [WORD_W-1:0]    req_wdata,
  output logic                 rsp_done,
  output logic [WORD_W-1:0]    rsp_rdata,
  input  logic                 dbg_valid,
  input  logic                 dbg_write,
  input  logic [DBG_IDX_W-1:0] dbg_idx,
  input  logic [WORD_W-1:0]    dbg_wdata,
  output logic [WORD_W-1:0]    dbg_rdata,
  output logic                 cfg_prog32,
  output logic                 cfg_data32,
  output logic                 cfg_late_abort,
  output logic                 cfg_big_endian,
  output logic                 mode_change
);
  idx_t  core_idx, dbg_sel;
  logic  dbg_ok;
  word_t rd_core, rd_dbg;
  logic [NUM_CFG-1:0] cfg_q, cfg_new;
  logic  we_core, we_dbg, hit_core, hit_dbg;

  cfgcp_decode #(.DBG_IDX_W(DBG_IDX_W)) u_dec (
    .rn_field     (req_instr[RN_LSB +: IDX_W]),
    .dbg_idx      (dbg_idx),
    .core_idx     (core_idx),
    .dbg_sel      (dbg_sel),
    .dbg_in_range (dbg_ok)
  );

  assign we_core = req_valid && req_write;
  assign we_dbg  = dbg_valid && dbg_write && dbg_ok;

  cfgcp_regfile u_rf (
    .clk    (clk),
    .rst_n  (rst_n),
    .strap  (strap_cfg),
    .we_a   (we_core),
    .idx_a  (core_idx),
    .d_a    (req_wdata),
    .we_b   (we_dbg),
    .idx_b  (dbg_sel),
    .d_b    (dbg_wdata),
    .ridx_a (core_idx),
    .ridx_b (dbg_sel),
    .rd_a   (rd_core),
    .rd_b   (rd_dbg),
    .cfg    (cfg_q)
  );

  // core port wins when both ports target the configuration register
  assign hit_core = we_core && core_idx == idx_t'(CFG_REG);
  assign hit_dbg  = we_dbg  && dbg_sel  == idx_t'(CFG_REG);
  assign cfg_new  = hit_core ? req_wdata[CFG_LSB +: NUM_CFG]
                             : dbg_wdata[CFG_LSB +: NUM_CFG];

  cfgcp_modewatch u_mw (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_cur (cfg_q),
    .cfg_we  (hit_core || hit_dbg),
    .cfg_new (cfg_new),
    .pulse   (mode_change)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_done  <= 1'b0;
      rsp_rdata <= '0;
      dbg_rdata <= '0;
    end else begin
      rsp_done <= req_valid;
      if (req_valid && !req_write)           rsp_rdata <= rd_core;
      if (dbg_valid && !dbg_write && dbg_ok) dbg_rdata <= rd_dbg;
    end
  end

  assign cfg_prog32     = cfg_q[0];
  assign cfg_data32     = cfg_q[1];
  assign cfg_late_abort = cfg_q[2];
  assign cfg_big_endian = cfg_q[3];
endmodule

// File: rtl/cfgcp_chk.sv
module cfgcp_chk
  import cfgcp_pkg::*;
#(
  parameter int unsigned DBG_IDX_W = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_write,
  input logic [WORD_W-1:0]    req_instr,
  input logic [WORD_W-1:0]    req_wdata,
  input logic                 rsp_done,
  input logic [WORD_W-1:0]    rsp_rdata,
  input logic                 dbg_valid,
  input logic                 dbg_write,
  input logic [DBG_IDX_W-1:0] dbg_idx,
  input logic [WORD_W-1:0]    dbg_rdata,
  input logic                 cfg_prog32,
  input logic                 cfg_data32,
  input logic                 cfg_late_abort,
  input logic                 cfg_big_endian,
  input logic                 mode_change
);
  logic [3:0] cfg_v;
  logic       any_wr, cfg_wr_core, dbg_bad, dbg_rd_ok;
  assign cfg_v       = {cfg_big_endian, cfg_late_abort, cfg_data32, cfg_prog32};
  assign any_wr      = (req_valid && req_write) || (dbg_valid && dbg_write);
  assign cfg_wr_core = req_valid && req_write && req_instr[RN_LSB +: IDX_W] == idx_t'(CFG_REG);
  assign dbg_bad     = dbg_valid && 32'(dbg_idx) >= NUM_REGS;
  assign dbg_rd_ok   = dbg_valid && !dbg_write && 32'(dbg_idx) < NUM_REGS;

  // R5
  done_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_done);
  // R5
  no_spurious_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_done);
  // R3
  id_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_instr[RN_LSB +: IDX_W] == '0) |=> rsp_rdata == ID_WORD);
  // R6
  cfg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any_wr |=> $stable(cfg_v));
  // R6
  cfg_follows_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_core |=> cfg_v == $past(req_wdata[7:4]));
  // R7
  pulse_means_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_change |-> cfg_v != $past(cfg_v));
  // R7
  change_means_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_v != $past(cfg_v) |-> mode_change);
  // R9
  dbg_oob_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_bad && !(req_valid && req_write)) |=> $stable(cfg_v) && $stable(dbg_rdata));
  // R11
  dbg_rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dbg_rd_ok |=> $stable(dbg_rdata));
  // R11
  rsp_rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> $stable(rsp_rdata));
endmodule

bind cfgcp_bank cfgcp_chk #(.DBG_IDX_W(DBG_IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_instr(req_instr), .req_wdata(req_wdata), .rsp_done(rsp_done),
  .rsp_rdata(rsp_rdata), .dbg_valid(dbg_valid), .dbg_write(dbg_write),
  .dbg_idx(dbg_idx), .dbg_rdata(dbg_rdata), .cfg_prog32(cfg_prog32),
  .cfg_data32(cfg_data32), .cfg_late_abort(cfg_late_abort),
  .cfg_big_endian(cfg_big_endian), .mode_change(mode_change)
);

// File: tb/cfgcp_bank_bench.sv
`timescale 1ns/1ps
module cfgcp_bank_bench;
  localparam logic [31:0] ID_EXP = 32'h4144_0110;
  localparam logic [3:0]  STRAP  = 4'b1010;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  strap_cfg = STRAP;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_instr = '0, req_wdata = '0;
  logic        rsp_done;
  logic [31:0] rsp_rdata;
  logic        dbg_valid = 1'b0, dbg_write = 1'b0;
  logic [3:0]  dbg_idx = '0;
  logic [31:0] dbg_wdata = '0, dbg_rdata;
  logic        cfg_prog32, cfg_data32, cfg_late_abort, cfg_big_endian, mode_change;

  always #2 clk = ~clk;

  cfgcp_bank u_cfgcp_bank (.*);

  int unsigned n_tests = 0, n_fail = 0;
  bit          finished = 1'b0;
  logic [31:0] mdl [8];
  logic [31:0] last_dbg = '0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input int r);
    return (r == 0) ? ID_EXP : mdl[r];
  endfunction

  function automatic logic [3:0] cfg_now();
    return {cfg_big_endian, cfg_late_abort, cfg_data32, cfg_prog32};
  endfunction

  // one core access followed by an idle cycle
  task automatic core_op(input bit wr, input int r, input logic [31:0] d, input logic [31:0] noise);
    logic [31:0] instr;
    logic [3:0]  old_cfg;
    bit          exp_mode;
    instr = (noise & ~32'h0007_0000) | (32'(r) << 16);
    old_cfg = mdl[1][7:4];
    exp_mode = wr && r == 1 && d[7:4] != old_cfg;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_instr = instr; req_wdata = d;
    @(posedge clk); #1;
    chk(rsp_done == 1'b1, "R5 done", 32'(rsp_done), 1);
    if (!wr) chk(rsp_rdata == exp_read(r), r == 0 ? "R3 id read" : "R4/R2 core read", rsp_rdata, exp_read(r));
    if (wr && r != 0) mdl[r] = d;
    chk(cfg_now() == mdl[1][7:4], "R6 cfg outputs", 32'(cfg_now()), 32'(mdl[1][7:4]));
    chk(mode_change == exp_mode, "R7 mode pulse", 32'(mode_change), 32'(exp_mode));
    @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk); #1;
    chk(rsp_done == 1'b0 && mode_change == 1'b0, "R5/R7 idle", {30'b0, rsp_done, mode_change}, 0);
  endtask

  task automatic dbg_op(input bit wr, input int idx, input logic [31:0] d);
    bit          inr;
    logic [31:0] exp_d;
    bit          exp_mode;
    inr = idx < 8;
    exp_mode = wr && idx == 1 && d[7:4] != mdl[1][7:4];
    exp_d = (!wr && inr) ? exp_read(idx) : last_dbg;
    @(negedge clk);
    dbg_valid = 1'b1; dbg_write = wr; dbg_idx = 4'(idx); dbg_wdata = d;
    @(posedge clk); #1;
    if (wr && inr && idx != 0) mdl[idx] = d;
    chk(dbg_rdata == exp_d, inr ? "R8 debug read" : "R9 debug out of range rdata", dbg_rdata, exp_d);
    chk(cfg_now() == mdl[1][7:4], inr ? "R8 cfg via debug" : "R9 cfg untouched", 32'(cfg_now()), 32'(mdl[1][7:4]));
    chk(mode_change == exp_mode, "R8 mode pulse", 32'(mode_change), 32'(exp_mode));
    chk(rsp_done == 1'b0, "R5 no done from debug", 32'(rsp_done), 0);
    last_dbg = exp_d;
    @(negedge clk);
    dbg_valid = 1'b0;
    @(posedge clk); #1;
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 8; i++) mdl[i] = '0;
    mdl[1] = {24'b0, STRAP, 4'b0};
    #10;
    // R1 reset state
    chk(cfg_now() == STRAP, "R1 cfg from straps", 32'(cfg_now()), 32'(STRAP));
    chk(rsp_done == 0 && mode_change == 0, "R1 outputs low", {30'b0, rsp_done, mode_change}, 0);
    chk(rsp_rdata == 0 && dbg_rdata == 0, "R1 read data zero", rsp_rdata | dbg_rdata, 0);
    @(negedge clk); rst_n = 1'b1;
    core_op(1'b0, 1, '0, '0);
    for (int r = 2; r < 8; r++) core_op(1'b0, r, '0, 32'hFFF0_FFFF);
    // R3 register 0 is fixed
    core_op(1'b1, 0, 32'hDEAD_BEEF, '0);
    core_op(1'b0, 0, '0, '0);
    dbg_op(1'b1, 0, 32'h1234_5678);
    dbg_op(1'b0, 0, '0);
    // R2 bit 19 set still selects the low three bits
    core_op(1'b1, 5, 32'hA5A5_0F0F, 32'h0008_0000);
    core_op(1'b0, 5, '0, '0);
    // R7 rewrite of same cfg bits gives no pulse, flip gives pulse
    core_op(1'b1, 1, {24'h0, STRAP, 4'hF}, '0);
    core_op(1'b1, 1, 32'h0000_0050, '0);
    // R9 out-of-range debug write and read
    dbg_op(1'b1, 9, 32'hFFFF_FFFF);
    dbg_op(1'b0, 12, '0);
    dbg_op(1'b0, 1, '0);
    // R10 simultaneous writes
    @(negedge clk);
    req_valid = 1; req_write = 1; req_instr = 32'h0003_0000; req_wdata = 32'h1111_1111;
    dbg_valid = 1; dbg_write = 1; dbg_idx = 4'd3; dbg_wdata = 32'h2222_2222;
    @(negedge clk);
    req_instr = 32'h0006_0000; req_wdata = 32'h6666_6666; dbg_idx = 4'd7; dbg_wdata = 32'h7777_7777;
    @(negedge clk);
    req_valid = 0; dbg_valid = 0;
    mdl[3] = 32'h1111_1111; mdl[6] = 32'h6666_6666; mdl[7] = 32'h7777_7777;
    core_op(1'b0, 3, '0, '0);
    core_op(1'b0, 6, '0, '0);
    dbg_op(1'b0, 7, '0);
    // random mix
    for (int k = 0; k < 400; k++) begin
      int          r;
      logic [31:0] d;
      r = int'($urandom % 8);
      d = $urandom;
      if (r == 1 && ($urandom % 3) == 0) d[7:4] = mdl[1][7:4];
      if ($urandom % 2) core_op(1'($urandom), r, d, $urandom);
      else              dbg_op(1'($urandom), int'($urandom % 16), d);
    end
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule